// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block sits on a two-wire serial bus as a target device and implements the write half of a byte-wide serial EEPROM. A bus master opens a transfer with a Start condition and sends a control byte. The control byte holds a fixed device-type code, a three-bit select value that must match the board straps, and a direction bit. The master then sends a two-byte word address, most significant byte first, followed by any number of data bytes. The data bytes collect in a 32-byte page buffer. The Stop condition that ends the transfer launches a timed internal write cycle, which copies the received bytes into the storage array. Page bytes that were not received in that transfer keep their stored values.

The bus lines are sampled by the system clock through two-stage synchronizers. Start and Stop are recognised as SDA edges while SCL is high. The block pulls SDA low through an output enable, and does so only to acknowledge. The write-protect input is looked at only at the Stop edge. A protected transfer is acknowledged normally and then discarded, and the block is free at once. While the write cycle runs, the block ignores the bus. The array is presented on a combinational read port for the neighbouring read engine, and the current address pointer is exported for the same purpose.

Top module: `eeprom_page_writer`

## Requirements
- R1: A control byte whose upper nibble is 4'b1010, whose bits [3:1] equal `csStrap` and whose bit 0 (direction) is 0 is acknowledged: `sdaOe` is high while SCL is high on the ninth clock of that byte.
- R2: A control byte with any other code, a different select value or bit 0 set gets no acknowledge, and neither does any later byte until the next Start. The array is left unchanged.
- R3: After an accepted control byte, the next two bytes are acknowledged and load the address pointer as {high byte, low byte}. Bits of the high byte above the array's address width are ignored, and `ptrAddr` shows the new address once the low byte is acknowledged.
- R4: Each data byte is acknowledged and buffered at the pointer's low 5 bits, and then only those 5 bits increment. Bytes past a page end wrap to the start of the same page, and a 33rd byte overwrites the first.
- R5: A Stop after at least one data byte, with `wpIn` low at the Stop, raises `busy` for exactly WRITE_CYCLES clocks. When `busy` falls, every received page byte is in the array, and all other bytes, inside and outside the page, are unchanged.
- R6: A Start that arrives while `busy` is high is ignored, so the control byte that follows gets no acknowledge.
- R7: If `wpIn` is high at the Stop, the transfer is still fully acknowledged, `busy` never rises and the array is unchanged. If `wpIn` changes after the Stop, the running write cycle is not affected.
- R8: After a write of one byte, `ptrAddr` holds the next location within the same page, so offset 31 is followed by offset 0.
- R9: During and right after reset, `busy` and `sdaOe` are low and `ptrAddr` is 0.
- R10: A Stop that follows only the address bytes, with no data byte, starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull SDA low when high (open-drain enable) |
| csStrap | input | 3 | Board strap value the select field must equal |
| wpIn | input | 1 | Write protect, sampled at Stop |
| busy | output | 1 | Internal write cycle in progress |
| ptrAddr | output | ADDR_W | Current address pointer |
| probeAddr | input | ADDR_W | Array read address for the read engine |
| probeData | output | 8 | Array byte at `probeAddr` |

## Verification
The bench builds the block with ADDR_W = 11, which gives a 2K-byte array with 64 pages. At that size the whole array can be read back and compared after every transfer, so a write that spills into a neighbouring page, or that touches a byte it should leave alone, cannot go unnoticed. WRITE_CYCLES = 48 keeps the write cycle longer than the 32 commit clocks but shorter than one bus byte. This lets the bench place a restart and a late write-protect change inside a running cycle and still have an exact busy length to check.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  // Fixed device-type code carried in the upper nibble of the control byte.
  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Which byte of a write command the receiver is collecting.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA
  } phase_t;

  // Strobes from the bus control to the datapath, one clock wide each.
  typedef struct packed {
    logic shiftEn;    // sample one data bit into the receive shifter
    logic shiftBit;   // the bit value to sample
    logic loadHi;     // acknowledged high address byte
    logic loadLo;     // acknowledged low address byte
    logic storeData;  // acknowledged data byte
    logic stopSeen;   // Stop that closes an accepted write command
  } dpStrobe_t;

endpackage

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] csStrap,
  input  logic [7:0] rxByte,
  input  logic       busyIn,
  output dpStrobe_t  strb,
  output logic       sdaOe
);

  // Two-stage synchronizers plus one delayed copy for edge detection.
  logic [1:0] sclQ, sdaQ;
  logic       sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 2'b11;
      sdaQ <= 2'b11;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[0], sclIn};
      sdaQ <= {sdaQ[0], sdaIn};
      sclD <= sclQ[1];
      sdaD <= sdaQ[1];
    end
  end

  logic sclNow, sdaNow;
  logic sclRise, sclFall, startDet, stopDet;

  assign sclNow   = sclQ[1];
  assign sdaNow   = sdaQ[1];
  assign sclRise  = sclNow & ~sclD;
  assign sclFall  = ~sclNow & sclD;
  assign startDet = sclNow & sclD & sdaD & ~sdaNow;
  assign stopDet  = sclNow & sclD & ~sdaD & sdaNow;

  phase_t     phase, nextPhase;
  logic [3:0] bitCnt;     // rising SCL edges seen in this byte, 0..9
  logic       cmdValid;   // control byte of this transfer was accepted
  logic       ctrlOk, ackNow, byteEnd;

  assign ctrlOk  = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == csStrap) && !rxByte[0];
  assign ackNow  = !busyIn && ((phase != PH_CTRL) || ctrlOk);
  assign byteEnd = sclFall && (phase != PH_IDLE) && (bitCnt == 4'd8);

  always_comb begin
    case (phase)
      PH_CTRL:    nextPhase = PH_ADDR_HI;
      PH_ADDR_HI: nextPhase = PH_ADDR_LO;
      PH_ADDR_LO: nextPhase = PH_DATA;
      PH_DATA:    nextPhase = PH_DATA;
      default:    nextPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.shiftBit = sdaNow;
    strb.shiftEn  = sclRise && (phase != PH_IDLE) && (bitCnt < 4'd8);
    if (byteEnd && ackNow) begin
      case (phase)
        PH_ADDR_HI: strb.loadHi    = 1'b1;
        PH_ADDR_LO: strb.loadLo    = 1'b1;
        PH_DATA:    strb.storeData = 1'b1;
        default:    ;
      endcase
    end
    strb.stopSeen = stopDet && cmdValid && !busyIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
      cmdValid <= 1'b0;
    end else if (startDet) begin
      phase    <= busyIn ? PH_IDLE : PH_CTRL;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
      cmdValid <= 1'b0;
    end else if (stopDet) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
      cmdValid <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (sclRise && bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
      if (byteEnd) begin
        if (ackNow) begin
          sdaOe <= 1'b1;
          if (phase == PH_CTRL) cmdValid <= 1'b1;
        end else begin
          phase  <= PH_IDLE;
          bitCnt <= '0;
        end
      end else if (sclFall && bitCnt == 4'd9) begin
        sdaOe  <= 1'b0;
        bitCnt <= '0;
        phase  <= nextPhase;
      end
    end
  end

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> !sdaOe); // R6

  AST_NACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && phase == PH_CTRL && !ctrlOk) |=> (phase == PH_IDLE && !sdaOe)); // R2

  AST_ONE_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHi, strb.loadLo, strb.storeData, strb.stopSeen})); // R3

endmodule

// File: rtl/eewr_dp.sv
module eewr_dp
  import eewr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [7:0]        rxByte,
  output logic              busy,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic [7:0]        probeData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int CW_RAW     = $clog2(WRITE_CYCLES + 1);
  localparam int CNT_W      = (CW_RAW > PAGE_W) ? CW_RAW : PAGE_W + 1;

  logic [7:0]            shiftReg;
  logic [HI_W-1:0]       hiHold;
  logic [ADDR_W-1:0]     ptr;
  logic [PAGE_BYTES-1:0] mask;
  logic [CNT_W-1:0]      cnt;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            mem     [DEPTH];

  logic [PAGE_W-1:0]     slot;
  logic [ADDR_W-1:0]     commitAddr;
  logic                  commitOn;

  assign slot       = cnt[PAGE_W-1:0];
  assign commitAddr = {ptr[ADDR_W-1:PAGE_W], slot};
  assign commitOn   = busy && (cnt < CNT_W'(PAGE_BYTES)) && mask[slot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiHold   <= '0;
      ptr      <= '0;
      mask     <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else begin
      if (strb.shiftEn) shiftReg <= {shiftReg[6:0], strb.shiftBit};
      if (strb.loadHi) begin
        hiHold <= shiftReg[HI_W-1:0];
        mask   <= '0;
      end
      if (strb.loadLo) ptr <= {hiHold, shiftReg};
      if (strb.storeData) begin
        mask[ptr[PAGE_W-1:0]] <= 1'b1;
        ptr[PAGE_W-1:0]       <= ptr[PAGE_W-1:0] + 1'b1;
      end
      if (strb.stopSeen && |mask) begin
        if (wpIn) begin
          mask <= '0;
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
          busy <= 1'b0;
          mask <= '0;
        end
      end
    end
  end

  // Storage without reset: the page buffer fills from the bus, and the
  // array takes one buffered byte per clock during the write cycle.
  always_ff @(posedge clk) begin
    if (strb.storeData) pageBuf[ptr[PAGE_W-1:0]] <= shiftReg;
    if (commitOn) mem[commitAddr] <= pageBuf[slot];
  end

  assign rxByte    = shiftReg;
  assign ptrAddr   = ptr;
  assign probeData = mem[probeAddr];

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(strb.stopSeen) && !$past(wpIn))); // R5

  AST_WP_BLOCKS_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopSeen && wpIn && !busy) |=> !busy); // R7

  AST_NO_STORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeData |-> !busy); // R6

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeData |=> $stable(ptr[ADDR_W-1:PAGE_W])); // R4

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eewr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        csStrap,
  input  logic              wpIn,
  output logic              busy,
  output logic [ADDR_W-1:0] ptrAddr,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [7:0]        probeData
);

  dpStrobe_t  strb;
  logic [7:0] rxByte;

  eewr_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .csStrap (csStrap),
    .rxByte  (rxByte),
    .busyIn  (busy),
    .strb    (strb),
    .sdaOe   (sdaOe)
  );

  eewr_dp #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wpIn      (wpIn),
    .probeAddr (probeAddr),
    .rxByte    (rxByte),
    .busy      (busy),
    .ptrAddr   (ptrAddr),
    .probeData (probeData)
  );

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

  localparam int ADDR_W = 11;
  localparam int PAGE_W = 5;
  localparam int WC     = 48;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NVEC = 7;
  // {address[12:0], byte count[5:0], first data byte, wp, select}
  localparam logic [30:0] VEC [NVEC] = '{
    {13'h0005, 6'd1,  8'h11, 1'b0, 3'b101},
    {13'h0123, 6'd4,  8'h40, 1'b0, 3'b101},
    {13'h003C, 6'd8,  8'h80, 1'b0, 3'b101},
    {13'h1840, 6'd34, 8'h03, 1'b0, 3'b101},
    {13'h0200, 6'd3,  8'hA0, 1'b1, 3'b101},
    {13'h0300, 6'd2,  8'h55, 1'b0, 3'b010},
    {13'h07FF, 6'd1,  8'hEE, 1'b0, 3'b101}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic wpIn = 1'b0;
  logic [ADDR_W-1:0] probeAddr = '0;
  logic sdaOe, busy;
  logic [ADDR_W-1:0] ptrAddr;
  logic [7:0] probeData;
  logic sdaLine;

  int checks = 0;
  int failures = 0;
  int busyCnt = 0;
  logic busyClr = 1'b0;
  logic done = 1'b0;
  logic [7:0] model [DEPTH];

  assign sdaLine = sdaM & ~sdaOe;

  always #4 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .csStrap(STRAP), .wpIn(wpIn), .busy(busy), .ptrAddr(ptrAddr),
    .probeAddr(probeAddr), .probeData(probeData)
  );

  always @(negedge clk) begin
    if (busyClr) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; half(); scl = 1'b1; half(); sdaM = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic busStop();
    sdaM = 1'b0; half(); scl = 1'b1; half(); sdaM = 1'b1; half();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; half(); scl = 1'b1; half(); scl = 1'b0; half();
    end
    sdaM = 1'b1; half(); scl = 1'b1;
    repeat (5) @(negedge clk);
    ack = ~sdaLine;
    repeat (5) @(negedge clk);
    scl = 1'b0; half();
  endtask

  task automatic snapshot();
    for (int a = 0; a < DEPTH; a++) begin
      probeAddr = a[ADDR_W-1:0]; #1;
      model[a] = probeData;
    end
  endtask

  task automatic compareArray(input string req);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      probeAddr = a[ADDR_W-1:0]; #1;
      if (probeData !== model[a]) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic clearBusyCnt();
    busyClr = 1'b1; @(negedge clk); busyClr = 1'b0;
  endtask

  task automatic runWrite(input logic [12:0] addr, input int n, input logic [7:0] seed,
                          input logic wp, input logic [2:0] cs, input logic [3:0] code,
                          input logic rw);
    logic ack, expAck;
    logic [ADDR_W-1:0] a;
    int pg, off, ackBad, expBusy;
    logic [7:0] b;
    snapshot();
    expAck = (code == 4'hA) && (cs == STRAP) && !rw;
    a = addr[ADDR_W-1:0];
    pg = int'(a) & ~31;
    off = int'(a) & 31;
    ackBad = 0;
    busStart();
    sendByte({code, cs, rw}, ack);
    check(expAck ? "R1 control byte ack" : "R2 control byte nack", ack, expAck);
    sendByte({3'b110, addr[12:8]}, ack);
    check(expAck ? "R3 high address ack" : "R2 later byte nack", ack, expAck);
    sendByte(addr[7:0], ack);
    if (ack !== expAck) ackBad++;
    if (expAck) check("R3 pointer load, top bits ignored", ptrAddr, a);
    for (int k = 0; k < n; k++) begin
      b = seed + 8'(k * 7);
      sendByte(b, ack);
      if (ack !== expAck) ackBad++;
      if (expAck && !wp) model[pg + off] = b;
      off = (off + 1) % 32;
    end
    check(wp ? "R7 protected transfer still acked" : "R4 data byte acks", ackBad, 0);
    wpIn = wp;
    clearBusyCnt();
    busStop();
    repeat (WC + 20) @(negedge clk);
    wpIn = 1'b0;
    expBusy = (expAck && n > 0 && !wp) ? WC : 0;
    check(wp ? "R7 no cycle when protected" : "R5 busy length", busyCnt, expBusy);
    compareArray(wp ? "R7 array unchanged" : (expAck ? "R5 R4 array contents" : "R2 array unchanged"));
    if (expAck && n > 0)
      check(n == 1 ? "R8 pointer after single byte" : "R4 pointer low bits advance",
            ptrAddr, pg + off);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    check("R9 busy in reset", busy, 0);
    check("R9 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 busy after reset", busy, 0);
    check("R9 sdaOe after reset", sdaOe, 0);
    check("R9 pointer after reset", ptrAddr, 0);

    // Vector table: plain writes, page wrap, overwrite, protect, select mismatch.
    for (int v = 0; v < NVEC; v++) begin
      runWrite(VEC[v][30:18], int'(VEC[v][17:12]), VEC[v][11:4], VEC[v][3], VEC[v][2:0],
               4'hA, 1'b0);
    end

    // R2: wrong device code, then a read-direction control byte.
    runWrite(13'h0100, 2, 8'h21, 1'b0, STRAP, 4'hB, 1'b0);
    runWrite(13'h0100, 2, 8'h31, 1'b0, STRAP, 4'hA, 1'b1);

    // R10: address only, no data byte.
    snapshot();
    busStart();
    sendByte({4'hA, STRAP, 1'b0}, ack);
    sendByte(8'h04, ack);
    sendByte(8'h44, ack);
    clearBusyCnt();
    busStop();
    repeat (WC + 20) @(negedge clk);
    check("R10 no cycle without data", busyCnt, 0);
    check("R10 pointer loaded", ptrAddr, 11'h444);
    compareArray("R10 array unchanged");

    // R6 and R7: restart during the cycle, WP raised after the Stop.
    snapshot();
    busStart();
    sendByte({4'hA, STRAP, 1'b0}, ack);
    sendByte(8'h01, ack);
    sendByte(8'h50, ack);
    for (int k = 0; k < 3; k++) begin
      sendByte(8'h70 + 8'(k), ack);
      model[11'h150 + k] = 8'h70 + 8'(k);
    end
    clearBusyCnt();
    busStop();
    wpIn = 1'b1;
    check("R6 busy before restart", busy, 1);
    busStart();
    sendByte({4'hA, STRAP, 1'b0}, ack);
    check("R6 no ack for Start during busy", ack, 0);
    busStop();
    repeat (WC) @(negedge clk);
    wpIn = 1'b0;
    check("R7 late WP leaves cycle length", busyCnt, WC);
    compareArray("R7 late WP does not block commit");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule